// File: doc/BRIEF.md
# Resume-Flag Breakpoint Suppression Controller

This block holds the resume bit of a processor flags word and decides, for every instruction, whether a code-breakpoint match becomes a debug exception. While the bit is set, one instruction may run past a code breakpoint that would otherwise fire again. The bit clears itself when that instruction starts, so the suppression lasts for exactly one instruction. Data-breakpoint matches and other faults are never masked by it.

On event entry the block supplies the resume value that belongs in the stacked flags image. That value depends on the event class (fault, trap, hardware interrupt, software interrupt, or debug entry caused by an instruction breakpoint) and on whether a repeated string instruction stopped before its last iteration. A return-from-event loads the bit from the stacked image. A plain flags pop never touches it. Instruction decode, stack memory and the other flag bits belong to neighbouring logic.

Top module: `rfx_resume_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `rf_live` is 0 and `dbg_req`, `code_dbg` and `fault_req` are 0 when no strobe is active.
- R2: In a cycle with `insn_start` and `code_bp_hit` both high and `rf_live` 0, `code_dbg` and `dbg_req` are 1 in that same cycle. A `code_bp_hit` without `insn_start` raises neither.
- R3: While `rf_live` is 1, a code-breakpoint match at instruction start raises neither `code_dbg` nor `dbg_req`.
- R4: An `insn_start` without `evt_return` makes `rf_live` 0 from the next cycle on, so one set bit covers exactly one instruction.
- R5: An `evt_return` strobe loads `rf_live` from bit 16 of `ret_flags` at the next clock edge. This takes priority over a clear in the same cycle.
- R6: A `flags_pop` strobe leaves `rf_live` unchanged, whatever value bit 16 of `pop_flags` holds.
- R7: For class code 0 (fault), `push_rf` is 1 in the cycle of `evt_enter`.
- R8: For class code 1 (trap) or 2 (hardware interrupt), with `rep_string` 1 and `rep_last` 0, `push_rf` is 1. With `rep_last` 1 it equals `rf_live`.
- R9: For class code 4 (instruction-breakpoint debug entry), and for codes 1 and 2 outside a non-final repeat iteration, `push_rf` equals `rf_live`. For class code 3 (software interrupt) it is 0.
- R10: Any bit of `data_bp_hit` raises `dbg_req` in the same cycle, and `fault_in` raises `fault_req`, whatever the value of `rf_live`.
- R11: When an unsuppressed code-breakpoint debug and `fault_in` fall in the same cycle, the debug wins: `code_dbg` and `dbg_req` are 1 and `fault_req` is 0.
- R12: Breakpoint replay: a hit raises a debug. Debug entry pushes 0. A return with the stacked bit set makes the restarted instruction pass its breakpoint without a second debug. After it starts and completes, `rf_live` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_start | input | 1 | Strobe: an instruction begins; the code-breakpoint check happens here |
| insn_done | input | 1 | Strobe: an instruction completed |
| code_bp_hit | input | 1 | The starting instruction matches a code breakpoint |
| data_bp_hit | input | NUM_DBP | Per-channel data or I/O breakpoint matches |
| fault_in | input | 1 | A non-debug fault is pending for this instruction |
| evt_enter | input | 1 | Strobe: an event handler is being entered |
| evt_class | input | 3 | Class of the entered event (0 fault, 1 trap, 2 hw int, 3 sw int, 4 ibp debug) |
| rep_string | input | 1 | The current instruction is a repeated string instruction |
| rep_last | input | 1 | This is the final iteration of the repeat |
| evt_return | input | 1 | Strobe: return-from-event |
| ret_flags | input | FLAG_W | Stacked flags image restored by the return |
| flags_pop | input | 1 | Strobe: plain flags pop |
| pop_flags | input | FLAG_W | Image popped by the plain pop |
| dbg_req | output | 1 | Debug exception request (code or data breakpoint) |
| code_dbg | output | 1 | The debug request comes from a code breakpoint |
| fault_req | output | 1 | Non-debug fault passed on after priority |
| push_rf | output | 1 | Resume value to store in the stacked image on entry |
| rf_live | output | 1 | Live resume bit |

## Verification
The checker assumes that `insn_start` and `evt_return` are never high together, that strobes last one cycle, and that `evt_class` holds only codes 0 to 4 while `evt_enter` is high. Under those assumptions the return, clear and pop rules can be stated one edge at a time. The bench drives every strobe for exactly one cycle from the falling edge and always deasserts it afterwards. It never overlaps a return with an instruction start, and it uses only the five defined class codes.

// File: rtl/rfx_pkg.sv
package rfx_pkg;
   localparam int CLASS_W = 3;
   typedef enum logic [CLASS_W-1:0] {
      EVC_FAULT  = 3'd0,
      EVC_TRAP   = 3'd1,
      EVC_HWINT  = 3'd2,
      EVC_SWINT  = 3'd3,
      EVC_IBPDBG = 3'd4
   } evt_class_e;
endpackage

// File: rtl/rfx_flag_reg.sv
module rfx_flag_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic insn_start,
   input  logic evt_return,
   input  logic ret_rf,
   output logic rf_q
);
   // A return restores the stacked bit; an instruction start clears it
   // after its breakpoint check has seen the old value.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          rf_q <= 1'b0;
      else if (evt_return) rf_q <= ret_rf;
      else if (insn_start) rf_q <= 1'b0;
   end
endmodule

// File: rtl/rfx_bp_gate.sv
module rfx_bp_gate #(
   parameter int NUM_DBP = 4
) (
   input  logic               rf,
   input  logic               insn_start,
   input  logic               code_bp_hit,
   input  logic [NUM_DBP-1:0] data_bp_hit,
   input  logic               fault_in,
   output logic               code_dbg,
   output logic               dbg_req,
   output logic               fault_req
);
   logic [NUM_DBP:0] data_any;

   assign data_any[0] = 1'b0;
   for (genvar i = 0; i < NUM_DBP; i++) begin : g_dbp
      assign data_any[i+1] = data_any[i] | data_bp_hit[i];
   end

   // Only code matches are gated by the resume bit.
   assign code_dbg  = insn_start & code_bp_hit & ~rf;
   assign dbg_req   = code_dbg | data_any[NUM_DBP];
   // Fixed priority: code-breakpoint debug above any other fault.
   assign fault_req = fault_in & ~code_dbg;
endmodule

// File: rtl/rfx_push_sel.sv
module rfx_push_sel
   import rfx_pkg::*;
#(
   parameter int PUSH_STAGE = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               evt_enter,
   input  logic [CLASS_W-1:0] evt_class,
   input  logic               rep_string,
   input  logic               rep_last,
   input  logic               rf,
   output logic               push_rf
);
   logic mid_repeat;
   logic push_d;

   assign mid_repeat = rep_string & ~rep_last;

   always_comb begin
      unique case (evt_class)
         EVC_FAULT:             push_d = 1'b1;
         EVC_TRAP, EVC_HWINT:   push_d = mid_repeat | rf;
         EVC_SWINT:             push_d = 1'b0;
         default:               push_d = rf;
      endcase
   end

   if (PUSH_STAGE == 0) begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign push_rf = evt_enter & push_d;
   end else begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) push_rf <= 1'b0;
         else        push_rf <= evt_enter & push_d;
      end
   end
endmodule

// File: rtl/rfx_resume_ctrl.sv
module rfx_resume_ctrl
   import rfx_pkg::*;
#(
   parameter int FLAG_W     = 32,
   parameter int RF_POS     = 16,
   parameter int NUM_DBP    = 4,
   parameter int PUSH_STAGE = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               insn_start,
   input  logic               insn_done,
   input  logic               code_bp_hit,
   input  logic [NUM_DBP-1:0] data_bp_hit,
   input  logic               fault_in,
   input  logic               evt_enter,
   input  logic [2:0]         evt_class,
   input  logic               rep_string,
   input  logic               rep_last,
   input  logic               evt_return,
   input  logic [FLAG_W-1:0]  ret_flags,
   input  logic               flags_pop,
   input  logic [FLAG_W-1:0]  pop_flags,
   output logic               dbg_req,
   output logic               code_dbg,
   output logic               fault_req,
   output logic               push_rf,
   output logic               rf_live
);
   localparam int RF_LSB_W = RF_POS;

   if (RF_POS >= FLAG_W) begin : g_bad_pos
      $error("RF_POS must lie inside the flags word");
   end
   if (NUM_DBP < 1) begin : g_bad_dbp
      $error("NUM_DBP must be at least 1");
   end
   if (PUSH_STAGE != 0 && PUSH_STAGE != 1) begin : g_bad_stage
      $error("PUSH_STAGE must be 0 or 1");
   end

   // Pops and the other flag bits are deliberately not observed.
   logic unused_inputs;
   assign unused_inputs = ^{pop_flags, flags_pop, insn_done,
                            ret_flags[RF_LSB_W-1:0], ret_flags[FLAG_W-1:RF_POS+1]};

   rfx_flag_reg u_flag (
      .clk        (clk),
      .rst_n      (rst_n),
      .insn_start (insn_start),
      .evt_return (evt_return),
      .ret_rf     (ret_flags[RF_POS]),
      .rf_q       (rf_live)
   );

   rfx_bp_gate #(.NUM_DBP(NUM_DBP)) u_gate (
      .rf          (rf_live),
      .insn_start  (insn_start),
      .code_bp_hit (code_bp_hit),
      .data_bp_hit (data_bp_hit),
      .fault_in    (fault_in),
      .code_dbg    (code_dbg),
      .dbg_req     (dbg_req),
      .fault_req   (fault_req)
   );

   rfx_push_sel #(.PUSH_STAGE(PUSH_STAGE)) u_push (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_enter  (evt_enter),
      .evt_class  (evt_class),
      .rep_string (rep_string),
      .rep_last   (rep_last),
      .rf         (rf_live),
      .push_rf    (push_rf)
   );
endmodule

// File: rtl/rfx_resume_ctrl_chk.sv
module rfx_resume_ctrl_chk #(
   parameter int FLAG_W     = 32,
   parameter int RF_POS     = 16,
   parameter int NUM_DBP    = 4,
   parameter int PUSH_STAGE = 0
) (
   input logic               clk,
   input logic               rst_n,
   input logic               insn_start,
   input logic               code_bp_hit,
   input logic [NUM_DBP-1:0] data_bp_hit,
   input logic               fault_in,
   input logic               evt_enter,
   input logic [2:0]         evt_class,
   input logic               rep_string,
   input logic               rep_last,
   input logic               evt_return,
   input logic [FLAG_W-1:0]  ret_flags,
   input logic               flags_pop,
   input logic               dbg_req,
   input logic               code_dbg,
   input logic               fault_req,
   input logic               push_rf,
   input logic               rf_live
);
   p_rst_r1: assert property (@(posedge clk) !rst_n |=> !rf_live);

   p_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      insn_start && code_bp_hit && !rf_live |-> code_dbg && dbg_req);

   p_one_per_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      code_dbg |-> insn_start);

   p_supp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rf_live |-> !code_dbg);

   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      insn_start && !evt_return |=> !rf_live);

   p_ret_r5: assert property (@(posedge clk) disable iff (!rst_n)
      evt_return |=> rf_live == $past(ret_flags[RF_POS]));

   p_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      flags_pop && !evt_return && !insn_start |=> $stable(rf_live));

   if (PUSH_STAGE == 0) begin : g_push_chk
      p_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
         evt_enter && evt_class == 3'd0 |-> push_rf);
      p_rep_r8: assert property (@(posedge clk) disable iff (!rst_n)
         evt_enter && (evt_class == 3'd1 || evt_class == 3'd2)
         && rep_string && !rep_last |-> push_rf);
      p_sw_r9: assert property (@(posedge clk) disable iff (!rst_n)
         evt_enter && evt_class == 3'd3 |-> !push_rf);
      p_ibp_r9: assert property (@(posedge clk) disable iff (!rst_n)
         evt_enter && evt_class == 3'd4 |-> push_rf == rf_live);
   end

   p_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (|data_bp_hit) |-> dbg_req);

   p_prio_r11: assert property (@(posedge clk) disable iff (!rst_n)
      fault_req |-> fault_in && !code_dbg);
endmodule

bind rfx_resume_ctrl rfx_resume_ctrl_chk #(
   .FLAG_W(FLAG_W), .RF_POS(RF_POS), .NUM_DBP(NUM_DBP), .PUSH_STAGE(PUSH_STAGE)
) u_chk (.*);

// File: tb/rfx_resume_ctrl_tb_top.sv
module rfx_resume_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int FLAG_W     = 32;
   localparam int NUM_DBP    = 4;
   localparam int WATCHDOG   = 5000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic insn_start, insn_done, code_bp_hit, fault_in;
   logic [NUM_DBP-1:0] data_bp_hit;
   logic evt_enter, rep_string, rep_last, evt_return, flags_pop;
   logic [2:0] evt_class;
   logic [FLAG_W-1:0] ret_flags, pop_flags;
   logic dbg_req, code_dbg, fault_req, push_rf, rf_live;

   int errors = 0;
   int checks = 0;
   bit reported = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rfx_resume_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .insn_start(insn_start), .insn_done(insn_done),
      .code_bp_hit(code_bp_hit), .data_bp_hit(data_bp_hit), .fault_in(fault_in),
      .evt_enter(evt_enter), .evt_class(evt_class), .rep_string(rep_string),
      .rep_last(rep_last), .evt_return(evt_return), .ret_flags(ret_flags),
      .flags_pop(flags_pop), .pop_flags(pop_flags), .dbg_req(dbg_req),
      .code_dbg(code_dbg), .fault_req(fault_req), .push_rf(push_rf), .rf_live(rf_live)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic idle();
      insn_start = 0; insn_done = 0; code_bp_hit = 0; fault_in = 0;
      data_bp_hit = '0; evt_enter = 0; evt_class = 3'd0; rep_string = 0;
      rep_last = 0; evt_return = 0; flags_pop = 0;
      ret_flags = '0; pop_flags = '0;
   endtask

   // Drive on the falling edge; combinational outputs are checked 1 ns later.
   task automatic next_cycle();
      @(negedge clk);
      idle();
   endtask

   task automatic set_rf(input logic v);
      @(negedge clk);
      idle();
      evt_return = 1;
      ret_flags = 32'hFFFE_FFFF;
      ret_flags[16] = v;
      next_cycle();
   endtask

   task automatic t_reset();
      idle();
      rst_n = 0;
      repeat (2) @(negedge clk);
      check("R1 rf_live in reset", rf_live, 1'b0);
      rst_n = 1;
      @(negedge clk); #1;
      check("R1 rf_live after reset", rf_live, 1'b0);
      check("R1 dbg_req idle", dbg_req, 1'b0);
      check("R1 fault_req idle", fault_req, 1'b0);
   endtask

   task automatic t_code_hit();
      set_rf(1'b0);
      code_bp_hit = 1; #1;
      check("R2 match without start", dbg_req, 1'b0);
      insn_start = 1; #1;
      check("R2 code_dbg on start", code_dbg, 1'b1);
      check("R2 dbg_req on start", dbg_req, 1'b1);
      next_cycle();
   endtask

   task automatic t_suppress();
      set_rf(1'b1);
      #1 check("R5 return loads bit 16", rf_live, 1'b1);
      insn_start = 1; code_bp_hit = 1; #1;
      check("R3 suppressed code_dbg", code_dbg, 1'b0);
      check("R3 suppressed dbg_req", dbg_req, 1'b0);
      next_cycle(); #1;
      check("R4 cleared after start", rf_live, 1'b0);
      insn_start = 1; code_bp_hit = 1; #1;
      check("R4 next insn hits again", code_dbg, 1'b1);
      next_cycle();
      // Return and start in distinct cycles; return with bit clear.
      set_rf(1'b1);
      set_rf(1'b0);
      #1 check("R5 return loads zero", rf_live, 1'b0);
   endtask

   task automatic t_pop();
      set_rf(1'b0);
      flags_pop = 1; pop_flags = 32'h0001_0000;
      next_cycle(); #1;
      check("R6 pop of set bit ignored", rf_live, 1'b0);
      set_rf(1'b1);
      flags_pop = 1; pop_flags = 32'h0000_0000;
      next_cycle(); #1;
      check("R6 pop of clear bit ignored", rf_live, 1'b1);
      insn_start = 1; code_bp_hit = 1; #1;
      check("R6 suppression survives pop", dbg_req, 1'b0);
      next_cycle();
   endtask

   task automatic t_push_classes();
      set_rf(1'b0);
      evt_enter = 1;
      evt_class = 3'd0; #1 check("R7 fault pushes 1", push_rf, 1'b1);
      evt_class = 3'd4; #1 check("R9 ibp debug pushes live 0", push_rf, 1'b0);
      evt_class = 3'd2; #1 check("R9 hw int pushes live 0", push_rf, 1'b0);
      evt_class = 3'd1; #1 check("R9 trap pushes live 0", push_rf, 1'b0);
      next_cycle();
      set_rf(1'b1);
      evt_enter = 1;
      evt_class = 3'd0; #1 check("R7 fault pushes 1 with bit set", push_rf, 1'b1);
      evt_class = 3'd4; #1 check("R9 ibp debug pushes live 1", push_rf, 1'b1);
      evt_class = 3'd2; #1 check("R9 hw int pushes live 1", push_rf, 1'b1);
      evt_class = 3'd3; #1 check("R9 sw int pushes 0", push_rf, 1'b0);
      next_cycle();
   endtask

   task automatic t_rep();
      set_rf(1'b0);
      evt_enter = 1; rep_string = 1; rep_last = 0;
      evt_class = 3'd2; #1 check("R8 hw int mid-repeat pushes 1", push_rf, 1'b1);
      evt_class = 3'd1; #1 check("R8 trap mid-repeat pushes 1", push_rf, 1'b1);
      evt_class = 3'd3; #1 check("R9 sw int mid-repeat pushes 0", push_rf, 1'b0);
      rep_last = 1;
      evt_class = 3'd2; #1 check("R8 hw int last iter pushes live", push_rf, 1'b0);
      evt_class = 3'd1; #1 check("R8 trap last iter pushes live", push_rf, 1'b0);
      next_cycle();
   endtask

   task automatic t_data_fault();
      set_rf(1'b1);
      data_bp_hit = 4'b0100; #1;
      check("R10 data bp with bit set", dbg_req, 1'b1);
      check("R10 data bp not code", code_dbg, 1'b0);
      data_bp_hit = 4'b0000; fault_in = 1; insn_start = 1; #1;
      check("R10 fault with bit set", fault_req, 1'b1);
      next_cycle();
      data_bp_hit = 4'b1000; #1;
      check("R10 data bp with bit clear", dbg_req, 1'b1);
      next_cycle();
   endtask

   task automatic t_prio();
      set_rf(1'b0);
      insn_start = 1; code_bp_hit = 1; fault_in = 1; #1;
      check("R11 debug wins dbg_req", dbg_req, 1'b1);
      check("R11 fault held back", fault_req, 1'b0);
      next_cycle();
      insn_start = 1; fault_in = 1; #1;
      check("R11 fault alone passes", fault_req, 1'b1);
      next_cycle();
   endtask

   task automatic t_replay();
      logic [FLAG_W-1:0] image;
      set_rf(1'b0);
      insn_start = 1; code_bp_hit = 1; #1;
      check("R12 first hit raises debug", dbg_req, 1'b1);
      next_cycle();
      evt_enter = 1; evt_class = 3'd4; #1;
      check("R12 debug entry pushes 0", push_rf, 1'b0);
      image = 32'h0000_0202;
      image[16] = push_rf;
      next_cycle();
      image[16] = 1'b1;              // handler sets the stacked bit
      evt_return = 1; ret_flags = image;
      next_cycle(); #1;
      check("R12 return sets live bit", rf_live, 1'b1);
      insn_start = 1; code_bp_hit = 1; #1;
      check("R12 restart has no second debug", dbg_req, 1'b0);
      next_cycle();
      insn_done = 1;
      next_cycle(); #1;
      check("R12 bit clear after completion", rf_live, 1'b0);
   endtask

   task automatic finish_run();
      if (!reported) begin
         reported = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=expired expected=done");
      finish_run();
   end

   initial begin
      t_reset();
      t_code_hit();
      t_suppress();
      t_pop();
      t_push_classes();
      t_rep();
      t_data_fault();
      t_prio();
      t_replay();
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule